// File: doc/BRIEF.md
# Weakly Ordered Store Buffer

This block sits between a core's store pipeline and its level-one data cache. Each store (address, size, data) is placed at the tail of a circular array in program order. A store becomes eligible to write the cache only after the core signals that it has retired. It then leaves through a single commit port that carries one aligned 8-byte word per cycle with a byte mask. Commits are picked oldest-ready-first, where "ready" means the cache line is held with exclusive ownership. Because of that rule, stores to different lines may reach the cache out of program order. Every individual byte, however, is written in program order.

Each store is decoded into at most two chunks, one per aligned 8-byte word it touches. Each chunk has its own committed flag. A store that straddles a word boundary, and in particular one that straddles a line boundary, therefore commits each half as soon as that half's line is owned. A fence entry placed in the stream holds back every younger store until all older stores have committed.

When the committing chunk is the oldest outstanding chunk of its word, all younger graduated, unfenced chunks of the same word are folded into the same beat, and for each byte the youngest data wins. Entries are freed from the head in program order once all of their chunks are done.

Top module: `weak_store_buffer`

## Requirements
- R1: Entries are allocated at the tail in program order while `alloc_ready` is high. `alloc_ready` is low exactly when DEPTH entries are held, and an allocation offered while it is low is dropped and never reaches the cache.
- R2: A store writes nothing to the cache before it graduates. Each `grad_valid` pulse graduates the oldest store not yet graduated, and a pulse with no such store does nothing.
- R3: A chunk commits only while the ownership bit of its line is set. The line index is address bits [ADDR_W-1:LINE_LG] and selects bit `own_vec[line]`. Chunks on owned lines may commit ahead of older chunks on lines that are not owned.
- R4: Among the chunks that are allowed to commit, the oldest in program order is sent first.
- R5: For every byte, writes reach the cache in program order. A younger store never replaces a byte that an older store still has to write.
- R6: A fence allocated with `alloc_fence` set keeps every younger store from committing while the fence is held. The fence is freed when it reaches the head, and younger stores may commit from the next cycle on.
- R7: If the committing chunk is the oldest uncommitted chunk of its word, every younger graduated chunk of that word with no fence in between joins the same beat. Masks are ORed, and each byte carries the youngest store's data.
- R8: A store that crosses an 8-byte boundary commits as two beats, one per word. Each beat is issued when that word's own line is owned, even when the two words lie in different lines.
- R9: `alloc_size` 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Byte 0 of `alloc_data` goes to the store address. A beat gives `cm_word` = address>>3, `cm_mask` bit i for byte i of the word, and data byte i in `cm_data[8i+7:8i]`. Unmasked bytes are zero, and the mask is never zero.
- R10: At most one beat is issued per cycle. A beat appears on the outputs one cycle after the edge that made its chunk eligible. Fully committed leading entries are freed one cycle after their last beat, and `empty` then rises.
- R11: After reset the buffer is empty, `alloc_ready` is high and `cm_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate one entry this cycle |
| alloc_fence | input | 1 | The allocated entry is a fence rather than a store |
| alloc_addr | input | ADDR_W | Byte address of the store |
| alloc_size | input | 2 | Size code: 0/1/2/3 for 1/2/4/8 bytes |
| alloc_data | input | 64 | Store data, byte 0 at the address |
| alloc_ready | output | 1 | The buffer has a free entry |
| grad_valid | input | 1 | Retirement of the oldest ungraduated store |
| own_vec | input | NLINES | Per-line exclusive ownership |
| cm_valid | output | 1 | A commit beat is valid |
| cm_word | output | ADDR_W-3 | Aligned 8-byte word address of the beat |
| cm_mask | output | 8 | Byte enables of the beat |
| cm_data | output | 64 | Beat data |
| empty | output | 1 | No entry is held |

## Verification
Allocation and graduation each take effect at the edge that samples them. A beat becomes visible one cycle after the edge that made its chunk eligible, and that eligibility comes from a graduation or from the ownership bit rising. The entry is freed, and `empty` rises, one cycle after its last beat. When a fence leaves, the store after it commits two cycles after the last older beat. The directed tasks sample the ports at the falling edge that follows each of these edges. A monitor logs every beat with its cycle number and replays it into a byte model of memory. Ordering, merging and split behaviour are then judged from that log and that model, after enough idle cycles for every due beat to have appeared, and the absence of early beats is checked at the same points.

// File: rtl/sb_pkg.sv
// Shared definitions for the store buffer: store size codes and the
// byte-enable pattern each size produces before alignment.
package sb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } sb_size_e;

    localparam int BEAT_BYTES = 8;

    // Low-aligned byte enables for a store of the given size
    function automatic logic [7:0] size_ones(input sb_size_e sz);
        case (sz)
            SZ_BYTE:  return 8'h01;
            SZ_HALF:  return 8'h03;
            SZ_WORD:  return 8'h0F;
            default:  return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/sb_split.sv
// Decodes an incoming store into two aligned 8-byte chunks (the word
// holding the start address and the next word). The second chunk has a
// zero mask when the store fits in one word.
// Assumes: byte 0 of the data belongs at the store address.
module sb_split #(
    parameter  int ADDR_W = 10,
    localparam int WORD_W = ADDR_W - 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [63:0]       data_i,
    output logic [WORD_W-1:0] word0_o,
    output logic [WORD_W-1:0] word1_o,
    output logic [7:0]        mask0_o,
    output logic [7:0]        mask1_o,
    output logic [63:0]       data0_o,
    output logic [63:0]       data1_o
);
    import sb_pkg::*;

    logic [2:0]   ofs;
    logic [15:0]  m16;
    logic [127:0] d128;

    // Shift mask and data to the byte offset and cut them into two words
    always_comb begin
        ofs     = addr_i[2:0];
        m16     = {8'h00, size_ones(sb_size_e'(size_i))} << ofs;
        d128    = {64'h0, data_i} << {ofs, 3'b000};
        word0_o = addr_i[ADDR_W-1:3];
        word1_o = addr_i[ADDR_W-1:3] + 1'b1;
        mask0_o = m16[7:0];
        mask1_o = m16[15:8];
        data0_o = d128[63:0];
        data1_o = d128[127:64];
    end

endmodule

// File: rtl/sb_pick.sv
// Commit selector. Scans the held entries from oldest to youngest and
// picks the oldest chunk that is graduated, not yet committed, on an
// owned line, not behind a fence and not overlapping an older
// uncommitted chunk of the same word. If that chunk is the oldest
// outstanding chunk of its word, younger graduated unfenced chunks of
// the word are merged in, applied in age order so the youngest byte wins.
// Assumes: DEPTH is a power of two. Chunks of different words never share bytes.
module sb_pick #(
    parameter  int DEPTH  = 8,
    parameter  int WORD_W = 7,
    parameter  int LINE_W = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int NLINES = 1 << LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  head_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              fence_i [DEPTH],
    input  logic              grad_i  [DEPTH],
    input  logic [1:0]        done_i  [DEPTH],
    input  logic [WORD_W-1:0] word_i  [DEPTH][2],
    input  logic [7:0]        mask_i  [DEPTH][2],
    input  logic [63:0]       data_i  [DEPTH][2],
    input  logic [NLINES-1:0] own_vec_i,
    output logic [1:0]        take_o  [DEPTH],
    output logic              pk_valid_o,
    output logic [WORD_W-1:0] pk_word_o,
    output logic [7:0]        pk_mask_o,
    output logic [63:0]       pk_data_o
);

    logic              found;
    logic              merge_ok;
    logic              fence_seen;
    logic              fence_seen2;
    logic              blk;
    logic              same_old;
    logic              sel;
    int                xk;
    int                xc;
    logic [WORD_W-1:0] xw;
    logic [PTR_W-1:0]  ek;
    logic [PTR_W-1:0]  ej;

    // Find the oldest eligible chunk, then gather it and its merge partners
    always_comb begin
        found      = 1'b0;
        merge_ok   = 1'b0;
        fence_seen = 1'b0;
        xk         = 0;
        xc         = 0;
        xw         = '0;
        ek         = '0;
        ej         = '0;
        blk        = 1'b0;
        same_old   = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            ek = head_i + PTR_W'(k);
            if (k < int'(count_i)) begin
                if (fence_i[ek]) begin
                    fence_seen = 1'b1;
                end else begin
                    for (int c = 0; c < 2; c++) begin
                        blk      = 1'b0;
                        same_old = 1'b0;
                        for (int j = 0; j < k; j++) begin
                            ej = head_i + PTR_W'(j);
                            if (!fence_i[ej]) begin
                                for (int cj = 0; cj < 2; cj++) begin
                                    if (!done_i[ej][cj] && word_i[ej][cj] == word_i[ek][c]) begin
                                        same_old = 1'b1;
                                        if ((mask_i[ej][cj] & mask_i[ek][c]) != 8'h00)
                                            blk = 1'b1;
                                    end
                                end
                            end
                        end
                        if (!found && grad_i[ek] && !done_i[ek][c] && !fence_seen && !blk &&
                            own_vec_i[word_i[ek][c][WORD_W-1 -: LINE_W]]) begin
                            found    = 1'b1;
                            xk       = k;
                            xc       = c;
                            xw       = word_i[ek][c];
                            merge_ok = !same_old;
                        end
                    end
                end
            end
        end

        for (int e = 0; e < DEPTH; e++) take_o[e] = 2'b00;
        pk_mask_o   = 8'h00;
        pk_data_o   = 64'h0;
        fence_seen2 = 1'b0;
        sel         = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            ek = head_i + PTR_W'(k);
            if (k < int'(count_i)) begin
                if (fence_i[ek]) begin
                    fence_seen2 = 1'b1;
                end else begin
                    for (int c = 0; c < 2; c++) begin
                        sel = found && !done_i[ek][c] && word_i[ek][c] == xw &&
                              ((k == xk && c == xc) ||
                               (merge_ok && k > xk && grad_i[ek] && !fence_seen2));
                        if (sel) begin
                            take_o[ek][c] = 1'b1;
                            pk_mask_o     = pk_mask_o | mask_i[ek][c];
                            for (int b = 0; b < 8; b++) begin
                                if (mask_i[ek][c][b])
                                    pk_data_o[8*b +: 8] = data_i[ek][c][8*b +: 8];
                            end
                        end
                    end
                end
            end
        end
        pk_valid_o = found;
        pk_word_o  = xw;
    end

    // Only graduated entries may be taken for commit
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        AST_TAKE_GRADUATED: assert property (@(posedge clk) disable iff (!rst_n)
            (take_o[g] != 2'b00) |-> grad_i[g]); // R2
    end

endmodule

// File: rtl/sb_retire.sv
// Head reclamation. Counts the leading entries, from the head on,
// that are fences or have both chunks committed. All of them are freed
// in one cycle.
// Assumes: DEPTH is a power of two; done flags come from registered state.
module sb_retire #(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] head_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             fence_i [DEPTH],
    input  logic [1:0]       done_i  [DEPTH],
    output logic [CNT_W-1:0] pop_o
);

    logic             stop;
    logic [PTR_W-1:0] ek;

    // Walk from the head until the first entry still owing a write
    always_comb begin
        stop  = 1'b0;
        pop_o = '0;
        ek    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            ek = head_i + PTR_W'(k);
            if (k < int'(count_i) && !stop && (fence_i[ek] || done_i[ek] == 2'b11))
                pop_o = pop_o + 1'b1;
            else
                stop = 1'b1;
        end
    end

    AST_HEAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i != '0 && !fence_i[head_i] && done_i[head_i] != 2'b11) |-> (pop_o == '0)); // R10

endmodule

// File: rtl/weak_store_buffer.sv
// Weakly ordered store buffer between a core and its L1 data cache.
// Entries are allocated at the tail in program order and graduated in
// order on retirement. Each store is split into per-word chunks that
// commit oldest-ready-first through one aligned 8-byte port, with
// per-byte order, fence fencing and same-word merging. Entries are
// freed at the head in order.
// Assumes: DEPTH is a power of two, LINE_LG >= 3, and the cache accepts a beat every cycle.
module weak_store_buffer #(
    parameter  int DEPTH   = 8,
    parameter  int ADDR_W  = 10,
    parameter  int LINE_LG = 6,
    localparam int WORD_W  = ADDR_W - 3,
    localparam int NLINES  = 1 << (ADDR_W - LINE_LG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_fence,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [1:0]        alloc_size,
    input  logic [63:0]       alloc_data,
    output logic              alloc_ready,
    input  logic              grad_valid,
    input  logic [NLINES-1:0] own_vec,
    output logic              cm_valid,
    output logic [WORD_W-1:0] cm_word,
    output logic [7:0]        cm_mask,
    output logic [63:0]       cm_data,
    output logic              empty
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LINE_W = ADDR_W - LINE_LG;

    logic [PTR_W-1:0]  head;
    logic [PTR_W-1:0]  tail;
    logic [CNT_W-1:0]  count;

    logic              e_fence [DEPTH];
    logic              e_grad  [DEPTH];
    logic [1:0]        e_done  [DEPTH];
    logic [WORD_W-1:0] e_word  [DEPTH][2];
    logic [7:0]        e_mask  [DEPTH][2];
    logic [63:0]       e_data  [DEPTH][2];

    logic [WORD_W-1:0] s_word0, s_word1;
    logic [7:0]        s_mask0, s_mask1;
    logic [63:0]       s_data0, s_data1;

    logic [1:0]        take [DEPTH];
    logic              pk_valid;
    logic [WORD_W-1:0] pk_word;
    logic [7:0]        pk_mask;
    logic [63:0]       pk_data;
    logic [CNT_W-1:0]  pop_n;

    logic              alloc_fire;
    logic              g_found;
    logic [PTR_W-1:0]  g_idx;
    logic [PTR_W-1:0]  gk;

    sb_split #(.ADDR_W(ADDR_W)) u_split (
        .addr_i  (alloc_addr),
        .size_i  (alloc_size),
        .data_i  (alloc_data),
        .word0_o (s_word0),
        .word1_o (s_word1),
        .mask0_o (s_mask0),
        .mask1_o (s_mask1),
        .data0_o (s_data0),
        .data1_o (s_data1)
    );

    sb_pick #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_i     (head),
        .count_i    (count),
        .fence_i    (e_fence),
        .grad_i     (e_grad),
        .done_i     (e_done),
        .word_i     (e_word),
        .mask_i     (e_mask),
        .data_i     (e_data),
        .own_vec_i  (own_vec),
        .take_o     (take),
        .pk_valid_o (pk_valid),
        .pk_word_o  (pk_word),
        .pk_mask_o  (pk_mask),
        .pk_data_o  (pk_data)
    );

    sb_retire #(.DEPTH(DEPTH)) u_retire (
        .clk     (clk),
        .rst_n   (rst_n),
        .head_i  (head),
        .count_i (count),
        .fence_i (e_fence),
        .done_i  (e_done),
        .pop_o   (pop_n)
    );

    // Occupancy flags and the accepted-allocation strobe
    always_comb begin
        alloc_ready = (count != CNT_W'(DEPTH));
        empty       = (count == '0);
        alloc_fire  = alloc_valid && alloc_ready;
    end

    // Locate the oldest store still waiting for retirement
    always_comb begin
        g_found = 1'b0;
        g_idx   = '0;
        gk      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            gk = head + PTR_W'(k);
            if (k < int'(count) && !g_found && !e_grad[gk]) begin
                g_found = 1'b1;
                g_idx   = gk;
            end
        end
    end

    // Entry state, pointers and the registered commit port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head     <= '0;
            tail     <= '0;
            count    <= '0;
            cm_valid <= 1'b0;
            cm_word  <= '0;
            cm_mask  <= 8'h00;
            cm_data  <= 64'h0;
            for (int e = 0; e < DEPTH; e++) begin
                e_fence[e] <= 1'b0;
                e_grad[e]  <= 1'b0;
                e_done[e]  <= 2'b11;
            end
        end else begin
            cm_valid <= pk_valid;
            cm_word  <= pk_word;
            cm_mask  <= pk_mask;
            cm_data  <= pk_data;
            for (int e = 0; e < DEPTH; e++)
                e_done[e] <= e_done[e] | take[e];
            if (grad_valid && g_found)
                e_grad[g_idx] <= 1'b1;
            if (alloc_fire) begin
                e_fence[tail]   <= alloc_fence;
                e_grad[tail]    <= alloc_fence;
                e_done[tail]    <= alloc_fence ? 2'b11 : {s_mask1 == 8'h00, 1'b0};
                e_word[tail][0] <= s_word0;
                e_word[tail][1] <= s_word1;
                e_mask[tail][0] <= s_mask0;
                e_mask[tail][1] <= s_mask1;
                e_data[tail][0] <= s_data0;
                e_data[tail][1] <= s_data1;
                tail            <= tail + 1'b1;
            end
            head  <= head + PTR_W'(pop_n);
            count <= count + CNT_W'(alloc_fire) - pop_n;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R1
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready |=> (count <= $past(count))); // R1
    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !cm_valid); // R10
    AST_BEAT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> ((($past(own_vec) >> cm_word[WORD_W-1 -: LINE_W]) & NLINES'(1)) != '0)); // R3
    AST_BEAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> (cm_mask != 8'h00)); // R9

endmodule

// File: tb/sim_weak_store_buffer.sv
module sim_weak_store_buffer;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 10;
    localparam int NLINES = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic              alloc_fence = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic [1:0]        alloc_size = 2'd0;
    logic [63:0]       alloc_data = 64'h0;
    logic              alloc_ready;
    logic              grad_valid = 1'b0;
    logic [NLINES-1:0] own = '0;
    logic              cm_valid;
    logic [6:0]        cm_word;
    logic [7:0]        cm_mask;
    logic [63:0]       cm_data;
    logic              empty;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          nlog = 0;
    logic [6:0]  log_word [32];
    logic [7:0]  log_mask [32];
    logic [63:0] log_data [32];
    int          log_cyc  [32];
    logic [7:0]  mem [1024];
    bit          done_flag = 1'b0;

    weak_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_LG(6)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .alloc_fence (alloc_fence),
        .alloc_addr  (alloc_addr),
        .alloc_size  (alloc_size),
        .alloc_data  (alloc_data),
        .alloc_ready (alloc_ready),
        .grad_valid  (grad_valid),
        .own_vec     (own),
        .cm_valid    (cm_valid),
        .cm_word     (cm_word),
        .cm_mask     (cm_mask),
        .cm_data     (cm_data),
        .empty       (empty)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc++;

    // Beat monitor: log each beat and replay it into the byte model
    always @(posedge clk) begin
        #1;
        if (rst_n && cm_valid && nlog < 32) begin
            log_word[nlog] = cm_word;
            log_mask[nlog] = cm_mask;
            log_data[nlog] = cm_data;
            log_cyc[nlog]  = cyc;
            nlog++;
            for (int b = 0; b < 8; b++)
                if (cm_mask[b]) mem[{cm_word, 3'(b)}] = cm_data[8*b +: 8];
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_valid = 1'b0;
        grad_valid = 1'b0;
        own = '0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        nlog = 0;
        rst_n = 1'b1;
    endtask

    task automatic put_store(input logic [9:0] a, input logic [1:0] sz, input logic [63:0] d);
        alloc_valid = 1'b1; alloc_fence = 1'b0;
        alloc_addr = a; alloc_size = sz; alloc_data = d;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic put_fence();
        alloc_valid = 1'b1; alloc_fence = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0; alloc_fence = 1'b0;
    endtask

    task automatic retire_one();
        grad_valid = 1'b1;
        @(negedge clk);
        grad_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 empty", 64'(empty), 64'd1);
        check("R11 alloc_ready", 64'(alloc_ready), 64'd1);
        check("R11 cm_valid", 64'(cm_valid), 64'd0);
    endtask

    task automatic t_basic();
        do_reset();
        own = '1;
        put_store(10'h013, 2'd0, 64'hFFA5);
        idle(4);
        check("R2 no beat before graduation", 64'(nlog), 64'd0);
        check("R1 entry held", 64'(empty), 64'd0);
        retire_one();
        check("R10 beat not yet due", 64'(cm_valid), 64'd0);
        @(negedge clk);
        check("R10 beat due", 64'(cm_valid), 64'd1);
        check("R9 word", 64'(cm_word), 64'h2);
        check("R9 mask", 64'(cm_mask), 64'h08);
        check("R9 data", cm_data, 64'hA500_0000);
        @(negedge clk);
        check("R10 single beat", 64'(cm_valid), 64'd0);
        check("R10 empty after free", 64'(empty), 64'd1);
    endtask

    task automatic t_merge();
        do_reset();
        put_store(10'h020, 2'd0, 64'h11);
        put_store(10'h021, 2'd0, 64'h22);
        put_store(10'h022, 2'd0, 64'h33);
        put_store(10'h023, 2'd0, 64'h44);
        put_store(10'h021, 2'd0, 64'h99);
        repeat (5) retire_one();
        idle(3);
        check("R3 unowned line holds", 64'(nlog), 64'd0);
        own[0] = 1'b1;
        idle(4);
        check("R7 one merged beat", 64'(nlog), 64'd1);
        check("R7 merged word", 64'(log_word[0]), 64'h4);
        check("R7 merged mask", 64'(log_mask[0]), 64'h0F);
        check("R7 youngest byte wins", log_data[0], 64'h4433_9911);
        check("R10 empty after merge", 64'(empty), 64'd1);
    endtask

    task automatic t_order();
        do_reset();
        put_store(10'h048, 2'd3, 64'h0102_0304_0506_0708);
        put_store(10'h0C0, 2'd2, 64'hCAFE_F00D);
        put_store(10'h0C8, 2'd0, 64'h77);
        repeat (3) retire_one();
        own[3] = 1'b1;
        idle(4);
        check("R3 owned line goes ahead", 64'(nlog), 64'd2);
        check("R4 oldest ready first", 64'(log_word[0]), 64'h18);
        check("R4 next ready second", 64'(log_word[1]), 64'h19);
        check("R3 unowned store absent", 64'(mem[10'h048]), 64'h0);
        own[1] = 1'b1;
        idle(3);
        check("R3 late store commits", 64'(nlog), 64'd3);
        check("R9 full dword data", log_data[2], 64'h0102_0304_0506_0708);
    endtask

    task automatic t_fence();
        do_reset();
        put_store(10'h005, 2'd0, 64'h5A);
        put_fence();
        put_store(10'h105, 2'd0, 64'hB7);
        retire_one();
        retire_one();
        own[4] = 1'b1;
        idle(5);
        check("R6 younger held by fence", 64'(nlog), 64'd0);
        own[0] = 1'b1;
        idle(5);
        check("R6 both commit", 64'(nlog), 64'd2);
        check("R6 older first", 64'(log_word[0]), 64'h0);
        check("R6 younger second", 64'(log_word[1]), 64'h20);
        check("R6 fence release delay", 64'(log_cyc[1] - log_cyc[0]), 64'd2);
        check("R6 empty", 64'(empty), 64'd1);
    endtask

    task automatic t_split();
        do_reset();
        put_store(10'h03C, 2'd3, 64'h8877_6655_4433_2211);
        put_store(10'h040, 2'd2, 64'hDDCC_BBAA);
        retire_one();
        retire_one();
        own[1] = 1'b1;
        idle(4);
        check("R8 upper half alone", 64'(nlog), 64'd1);
        check("R8 upper word", 64'(log_word[0]), 64'h8);
        check("R8 upper mask", 64'(log_mask[0]), 64'h0F);
        check("R5 younger overlap wins", log_data[0], 64'hDDCC_BBAA);
        check("R8 lower half waits", 64'(mem[10'h03C]), 64'h0);
        own[0] = 1'b1;
        idle(4);
        check("R8 lower half commits", 64'(nlog), 64'd2);
        check("R8 lower word", 64'(log_word[1]), 64'h7);
        check("R8 lower mask", 64'(log_mask[1]), 64'hF0);
        check("R8 lower data", log_data[1], 64'h4433_2211_0000_0000);
        check("R8 empty", 64'(empty), 64'd1);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++)
            put_store(10'(10'h200 + 8 * i), 2'd0, 64'(i + 1));
        check("R1 full", 64'(alloc_ready), 64'd0);
        put_store(10'h300, 2'd0, 64'hEE);
        check("R1 still held", 64'(empty), 64'd0);
        repeat (DEPTH + 1) retire_one();
        own = '1;
        idle(20);
        check("R1 beats for accepted stores", 64'(nlog), 64'(DEPTH));
        check("R1 dropped store never written", 64'(mem[10'h300]), 64'h0);
        check("R1 last accepted store", 64'(mem[10'h238]), 64'h8);
        check("R1 room again", 64'(alloc_ready), 64'd1);
        check("R10 drained", 64'(empty), 64'd1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_merge();
        t_order();
        t_fence();
        t_split();
        t_full();
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule